// File: doc/BRIEF.md
# Steered One-Shot Watchdog Timer

This block is a one-shot watchdog controlled through a single byte-wide control register. Software writes a timeout made of a 5-bit multiplier and a 2-bit power-of-four scale. The block then counts pulses on a 16 Hz tick-enable input. When the count runs out, the block sets a sticky watchdog flag, which a neighbouring flags register presents as its bit 7. The most significant bit of the control byte selects the action taken on expiry. One setting raises a one-cycle reset request, clears the control byte and tells the neighbouring day/century register to drop its bit 6. The other setting raises a one-cycle interrupt pulse.

Any write or read of the control register restarts the countdown and clears the flag. A write loads the new value. A read reloads the value already held. After expiry the counter stays idle until the next restart. The block does not generate the clock or the 16 Hz tick, and it does not perform the system reset itself.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control byte reads 0x00, the flag is 0, and reset request, interrupt and century-clear are all 0.
- R2: The timeout in ticks is the field in bits 6..2 multiplied by 4 raised to the field in bits 1..0. Expiry happens on the clock edge that samples the last tick, and only edges where the tick input is 1 are counted.
- R3: A control value of 0x00 disables the watchdog. No expiry occurs however many ticks arrive.
- R4: A value whose bits 6..2 are zero gives a zero timeout and is also disabled, whatever bits 1..0 and bit 7 hold.
- R5: A write loads the byte into the control register, restarts the countdown from the new value, and clears the flag on the next edge.
- R6: A read restarts the countdown from the held value and clears the flag. If a read and a write occur in the same cycle, the write value is used.
- R7: Expiry sets the flag in the same cycle as the action pulse. The flag then stays set until a write or read.
- R8: With bit 7 = 1 at expiry, the reset request and the century-clear output are each high for exactly one cycle, and the control byte reads 0x00 from that cycle on.
- R9: With bit 7 = 0 at expiry, the interrupt output is high for exactly one cycle, and the control byte keeps its value.
- R10: The counter is one-shot. After an expiry, no further pulse occurs until a restart.
- R11: A restart in the same cycle as the final tick takes precedence: no expiry occurs in that cycle.
- R12: Ticks that arrive while the watchdog is idle or disabled have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle count enable at 16 Hz |
| wd_wr | input | 1 | Write strobe for the control register |
| wd_rd | input | 1 | Read strobe for the control register (restarts the count) |
| wd_wdata | input | 8 | Write data |
| wd_rdata | output | 8 | Current control register contents |
| wd_flag | output | 1 | Sticky expiry flag (bit 7 of the flags register) |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| cent_clr | output | 1 | One-cycle request to clear bit 6 of the day/century register |

## Verification
The assertions assume that the strobes and tick input are clean, synchronous single-cycle levels. They also assume that a read strobe reflects a real register access, so any restart they see is one software intended. The stimulus changes inputs only on falling clock edges. It holds each strobe for one cycle, except where a read is deliberately overlapped with a write or with the final tick. Tick trains are either back-to-back or broken by idle gaps, so the count is shown to advance only on enabled edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    ON_EXPIRE_IRQ   = 1'b0,
    ON_EXPIRE_RESET = 1'b1
  } expire_action_e;

  // Timeout in ticks: multiplier scaled by 4**scale.
  function automatic int unsigned wd_ticks(input int unsigned mult,
                                           input int unsigned scale);
    return mult << (2 * scale);
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        clear_reg,
  output logic [DATA_W-1:0]           reg_q,
  output logic                        restart,
  output logic [CNT_W-1:0]            load_val,
  output wdog_pkg::expire_action_e    action
);
  import wdog_pkg::*;

  localparam int STEER_BIT = DATA_W - 1;

  function automatic logic [CNT_W-1:0] timeout_of(input logic [DATA_W-1:0] v);
    int unsigned m;
    int unsigned s;
    m = 32'(v[RES_W +: MULT_W]);
    s = 32'(v[RES_W-1:0]);
    return CNT_W'(wd_ticks(m, s));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr) begin
      reg_q <= wdata;
    end else if (clear_reg) begin
      reg_q <= '0;
    end
  end

  assign restart  = wr | rd;
  assign load_val = wr ? timeout_of(wdata) : timeout_of(reg_q);
  assign action   = expire_action_e'(reg_q[STEER_BIT]);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = active & tick & ~restart & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (restart) begin
      cnt_q  <= load_val;
      active <= (load_val != '0);
    end else if (expire) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (active && tick) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     expire,
  input  logic                     restart,
  input  wdog_pkg::expire_action_e action,
  output logic                     clear_reg,
  output logic                     flag,
  output logic                     rst_req,
  output logic                     irq_pulse,
  output logic                     cent_clr
);
  import wdog_pkg::*;

  logic to_reset;
  assign to_reset  = (action == ON_EXPIRE_RESET);
  assign clear_reg = expire & to_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      rst_req   <= 1'b0;
      irq_pulse <= 1'b0;
      cent_clr  <= 1'b0;
    end else begin
      rst_req   <= expire & to_reset;
      cent_clr  <= expire & to_reset;
      irq_pulse <= expire & ~to_reset;
      if (restart)     flag <= 1'b0;
      else if (expire) flag <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int DATA_W = 8,
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic              wd_wr,
  input  logic              wd_rd,
  input  logic [DATA_W-1:0] wd_wdata,
  output logic [DATA_W-1:0] wd_rdata,
  output logic              wd_flag,
  output logic              rst_req,
  output logic              irq_pulse,
  output logic              cent_clr
);
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic                     restart;
  logic                     expire;
  logic                     active;
  logic                     clear_reg;
  logic [CNT_W-1:0]         load_val;
  wdog_pkg::expire_action_e action;

  wdog_ctrl_reg #(
    .DATA_W(DATA_W), .MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(wd_wr), .rd(wd_rd), .wdata(wd_wdata),
    .clear_reg(clear_reg), .reg_q(wd_rdata), .restart(restart),
    .load_val(load_val), .action(action)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .restart(restart),
    .load_val(load_val), .expire(expire), .active(active)
  );

  wdog_action u_act (
    .clk(clk), .rst_n(rst_n), .expire(expire), .restart(restart),
    .action(action), .clear_reg(clear_reg), .flag(wd_flag),
    .rst_req(rst_req), .irq_pulse(irq_pulse), .cent_clr(cent_clr)
  );

endmodule

// File: rtl/wdog_steer_checker.sv
module wdog_steer_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              rd,
  input logic              expire,
  input logic              active,
  input logic [DATA_W-1:0] rdata,
  input logic              flag,
  input logic              rst_req,
  input logic              irq_pulse,
  input logic              cent_clr
);
  AST_RST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R9
  AST_ACTION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_pulse)); // R8
  AST_CENT_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cent_clr == rst_req); // R8
  AST_REG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rdata == '0); // R8
  AST_IRQ_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $stable(rdata)); // R9
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (rst_req || irq_pulse)); // R7
  AST_FLAG_CLEARS_ONLY_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr || rd)); // R7
  AST_RESTART_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) |=> !flag); // R5
  AST_EXPIRE_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req || irq_pulse)); // R2
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) |=> !(rst_req || irq_pulse)); // R11
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq_pulse) |-> !active); // R10
endmodule

bind wdog_steer wdog_steer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wd_wr), .rd(wd_rd), .expire(expire),
  .active(active), .rdata(wd_rdata), .flag(wd_flag), .rst_req(rst_req),
  .irq_pulse(irq_pulse), .cent_clr(cent_clr)
);

// File: tb/wdog_steer_test.sv
module wdog_steer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       flag, rreq, irq, cclr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int irq_seen = 0;
  int rst_seen = 0;

  // reference model state
  int m_ctrl = 0, m_cnt = 0;
  bit m_act = 0, m_flag = 0, m_rst = 0, m_irq = 0, m_cent = 0;

  always #5 clk = ~clk;

  wdog_steer uut (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick), .wd_wr(wr), .wd_rd(rd),
    .wd_wdata(wdata), .wd_rdata(rdata), .wd_flag(flag), .rst_req(rreq),
    .irq_pulse(irq), .cent_clr(cclr)
  );

  function automatic int ref_timeout(int v);
    int t;
    t = (v / 4) % 32;
    for (int i = 0; i < v % 4; i++) t = t * 4;
    return t;
  endfunction

  always @(posedge clk) begin
    m_rst = 0; m_irq = 0; m_cent = 0;
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_act = 0; m_flag = 0;
    end else if (wr || rd) begin
      if (wr) m_ctrl = int'(wdata);
      m_cnt = ref_timeout(m_ctrl);
      m_act = (m_cnt != 0);
      m_flag = 0;
    end else if (m_act && tick) begin
      if (m_cnt == 1) begin
        m_act = 0; m_cnt = 0; m_flag = 1;
        if (m_ctrl >= 128) begin m_rst = 1; m_cent = 1; m_ctrl = 0; end
        else m_irq = 1;
      end else m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      chk("R5 R8 control byte", int'(rdata), m_ctrl);
      chk("R7 flag", int'(flag), int'(m_flag));
      chk("R8 reset request", int'(rreq), int'(m_rst));
      chk("R8 century clear", int'(cclr), int'(m_cent));
      chk("R9 interrupt", int'(irq), int'(m_irq));
      irq_seen += int'(irq);
      rst_seen += int'(rreq);
    end
  end

  task automatic wr_reg(logic [7:0] v);
    wr = 1; wdata = v; @(negedge clk); wr = 0;
  endtask
  task automatic rd_reg();
    rd = 1; @(negedge clk); rd = 0;
  endtask
  task automatic ticks(int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 rdata", int'(rdata), 0); chk("R1 flag", int'(flag), 0);
    chk("R1 pulses", int'(rreq | irq | cclr), 0);
    // R12 ticks while idle
    ticks(10); chk("R12 idle ticks", int'(flag | irq | rreq), 0);

    // R2 R9: 0x0D = mult 3, scale 1 -> 12 ticks, interrupt steering
    wr_reg(8'h0D); chk("R5 readback", int'(rdata), 8'h0D);
    ticks(11); chk("R2 before expiry", int'(flag), 0);
    ticks(1); chk("R2 expiry flag", int'(flag), 1); chk("R9 irq", int'(irq), 1);
    chk("R9 reg kept", int'(rdata), 8'h0D);
    @(negedge clk); chk("R9 irq single", int'(irq), 0);
    base = irq_seen; ticks(20);
    chk("R10 one-shot", irq_seen - base, 0); chk("R7 flag held", int'(flag), 1);

    // R5 write restarts and clears flag
    wr_reg(8'h04); chk("R5 flag cleared", int'(flag), 0);
    ticks(1); chk("R2 one tick", int'(irq), 1);
    @(negedge clk);

    // R2 gaps: 0x09 = 8 ticks with idle gaps
    wr_reg(8'h09); ticks(3); repeat (5) @(negedge clk);
    ticks(4); chk("R2 gaps not counted", int'(flag), 0);
    ticks(1); chk("R2 gaps expiry", int'(flag), 1);

    // R6 read restarts with held value (0x08 = 2 ticks)
    wr_reg(8'h08); ticks(1); rd_reg();
    ticks(1); chk("R6 read restarted", int'(flag), 0);
    ticks(1); chk("R6 expiry after reload", int'(flag), 1);
    rd_reg(); chk("R6 read clears flag", int'(flag), 0);
    ticks(2); chk("R6 reload again", int'(flag), 1);

    // R6 write beats read in same cycle
    wr = 1; rd = 1; wdata = 8'h04; @(negedge clk); wr = 0; rd = 0;
    chk("R6 write wins", int'(rdata), 8'h04);
    ticks(1); chk("R6 new timeout used", int'(flag), 1);

    // R11 restart on final tick
    wr_reg(8'h04); tick = 1; rd = 1; @(negedge clk); tick = 0; rd = 0;
    chk("R11 no expiry", int'(flag | irq), 0);
    ticks(1); chk("R11 later expiry", int'(flag), 1);

    // R3 zero disables; write also clears flag
    wr_reg(8'h00); chk("R5 flag cleared by zero", int'(flag), 0);
    base = irq_seen + rst_seen; ticks(100);
    chk("R3 disabled", irq_seen + rst_seen - base + int'(flag), 0);

    // R4 zero multiplier, nonzero scale (and steering set)
    wr_reg(8'h83); ticks(100);
    chk("R4 disabled", irq_seen + rst_seen - base + int'(flag), 0);

    // R8 reset steering: 0x85 = mult 1, scale 1 -> 4 ticks
    wr_reg(8'h85); ticks(3); chk("R8 before", int'(rreq), 0);
    ticks(1); chk("R8 rst_req", int'(rreq), 1); chk("R8 cent_clr", int'(cclr), 1);
    chk("R8 reg zeroed", int'(rdata), 0); chk("R7 flag", int'(flag), 1);
    chk("R8 no irq", int'(irq), 0);
    @(negedge clk); chk("R8 single", int'(rreq | cclr), 0);
    base = rst_seen; ticks(50); chk("R10 no repeat", rst_seen - base, 0);
    rd_reg(); ticks(20); chk("R3 read of zero stays idle", int'(flag | rreq), 0);

    // R2 largest timeout 0x7F = 31*64 = 1984
    wr_reg(8'h7F); ticks(1983); chk("R2 max before", int'(flag), 0);
    ticks(1); chk("R2 max expiry", int'(irq), 1);
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule